// File: doc/BRIEF.md
# DRAM Low-Power State Sequencer

This block sits inside a graphics DRAM controller and owns the clock-enable pin and the low-power states of the memory. The rest of the controller raises a level request to place the memory in self-refresh or in power-down, and drops it again to bring the memory back. The sequencer drives clock enable and, while a transition settles, overrides the command bus with NOP or with the auto-refresh code that starts self-refresh. Two qualifiers go back to the controller. The first says when ordinary commands may be issued. The second says when reads in particular are allowed again.

The state machine has seven states. ST_ACTIVE is normal operation. ST_SR_ENTER is a single cycle that issues auto-refresh with clock enable low. ST_SR_HOLD is self-refresh. ST_SR_EXIT raises clock enable and sends only NOPs. ST_PD_ENTER is a single NOP cycle with clock enable low. ST_PD_HOLD is power-down. ST_PD_EXIT raises clock enable and sends only NOPs.

The transitions are as follows:
- ACTIVE→SR_ENTER when self-refresh is requested and all banks are idle.
- ACTIVE→PD_ENTER when power-down is requested, no self-refresh is requested and no refresh is due.
- SR_ENTER→SR_HOLD and PD_ENTER→PD_HOLD unconditionally.
- SR_HOLD→SR_EXIT when the request drops and the clock is stable.
- PD_HOLD→PD_EXIT when the request drops or a refresh falls due, in both cases with the clock stable.
- SR_EXIT→ACTIVE and PD_EXIT→ACTIVE when their NOP window expires.

A separate window that opens when clock enable rises after self-refresh keeps reads blocked until the DLL has had time to relock.

Top module: `dram_lowpower_seq`

## Requirements
- R1: After reset the block is in ST_ACTIVE with cke=1, cmd_ovr=2'b00 (no override), cmd_ok=1 and rd_ok=1.
- R2: A self-refresh request sampled in ST_ACTIVE with banks_idle high moves to ST_SR_ENTER. That state drives cke=0 and cmd_ovr=2'b10 (auto-refresh) for exactly one cycle. ST_SR_HOLD follows, with cke=0 and cmd_ovr=2'b01 (NOP).
- R3: A self-refresh request made while banks_idle is low stays pending in ST_ACTIVE, with cke=1 and cmd_ok=1, until banks_idle rises. When both requests are high, self-refresh wins over power-down.
- R4: In ST_SR_HOLD, a low sr_req together with a high clk_stable raises cke on the next cycle. The block then spends exactly XS_NOP_CYC cycles in ST_SR_EXIT with cmd_ovr=2'b01 and cmd_ok=0, and returns to ST_ACTIVE.
- R5: After a self-refresh exit, rd_ok stays low for exactly DLL_CYC cycles, counted from the first cycle with cke high. It rises on the next cycle if the block is in ST_ACTIVE.
- R6: A power-down request sampled in ST_ACTIVE, with sr_req and refresh_due low, gives one ST_PD_ENTER cycle and then ST_PD_HOLD. Both states drive cke=0 and cmd_ovr=2'b01.
- R7: While refresh_due is high, no power-down entry is made.
- R8: In ST_PD_HOLD, a low pd_req or a high refresh_due, with clk_stable high, starts an exit. The block holds cke=1, cmd_ovr=2'b01 and cmd_ok=0 for exactly PD_EXIT_CYC cycles, then returns to ST_ACTIVE. A power-down exit does not by itself block reads.
- R9: cmd_ok is high only in ST_ACTIVE. Whenever cke is low, cmd_ovr is not 2'b00.
- R10: cke never rises unless clk_stable was high at the preceding clock edge. While clk_stable is low, the block stays in its clock-enable-low state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_req | input | 1 | Level request for self-refresh; dropping it asks for exit |
| pd_req | input | 1 | Level request for power-down; dropping it asks for exit |
| banks_idle | input | 1 | High when no bank has an open row |
| clk_stable | input | 1 | High when the memory clock is stable |
| refresh_due | input | 1 | Refresh scheduler reports a refresh is needed |
| cke | output | 1 | Clock enable to the memory |
| cmd_ovr | output | 2 | Command override: 00 none, 01 NOP, 10 auto-refresh |
| cmd_ok | output | 1 | Ordinary commands may be issued |
| rd_ok | output | 1 | Read commands may be issued |

## Verification
Directed sequences come first:
- A self-refresh request held against busy banks, with power-down also requested, separates pending-and-priority behaviour from premature entry.
- A self-refresh exit attempted with the clock unstable, then allowed, separates the clock precondition from the request itself.
- Cycle counts of the low phases of cmd_ok and rd_ok tell the NOP-only window apart from the longer read-blocking window.
- A power-down request made while a refresh is due, then a refresh raised inside power-down, separates blocked entry from forced exit.

A long random phase then toggles all five inputs at different rates. Every output is compared on every cycle against a bench state model, which reaches mixed orderings such as re-entry during an open read window.

// File: rtl/lpseq_pkg.sv
`timescale 1ns/1ps
package lpseq_pkg;

    typedef enum logic [2:0] {
        ST_ACTIVE   = 3'd0,
        ST_SR_ENTER = 3'd1,
        ST_SR_HOLD  = 3'd2,
        ST_SR_EXIT  = 3'd3,
        ST_PD_ENTER = 3'd4,
        ST_PD_HOLD  = 3'd5,
        ST_PD_EXIT  = 3'd6
    } lp_state_e;

    typedef enum logic [1:0] {
        OVR_NONE = 2'b00,
        OVR_NOP  = 2'b01,
        OVR_AREF = 2'b10
    } cmd_ovr_e;

endpackage

// File: rtl/lpseq_timer.sv
`timescale 1ns/1ps
module lpseq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/lpseq_fsm.sv
`timescale 1ns/1ps
module lpseq_fsm
    import lpseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sr_req,
    input  logic      pd_req,
    input  logic      banks_idle,
    input  logic      clk_stable,
    input  logic      refresh_due,
    input  logic      win_zero,
    output lp_state_e state,
    output logic      go_sr_exit,
    output logic      go_pd_exit
);

    lp_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ACTIVE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        go_sr_exit = 1'b0;
        go_pd_exit = 1'b0;
        unique case (state_q)
            ST_ACTIVE: begin
                if (sr_req) begin
                    // self-refresh has priority; it waits here until all banks close
                    if (banks_idle) state_d = ST_SR_ENTER;
                end else if (pd_req && !refresh_due) begin
                    state_d = ST_PD_ENTER;
                end
            end
            ST_SR_ENTER: state_d = ST_SR_HOLD;
            ST_SR_HOLD: begin
                if (!sr_req && clk_stable) begin
                    state_d    = ST_SR_EXIT;
                    go_sr_exit = 1'b1;
                end
            end
            ST_SR_EXIT: begin
                if (win_zero) state_d = ST_ACTIVE;
            end
            ST_PD_ENTER: state_d = ST_PD_HOLD;
            ST_PD_HOLD: begin
                if ((!pd_req || refresh_due) && clk_stable) begin
                    state_d    = ST_PD_EXIT;
                    go_pd_exit = 1'b1;
                end
            end
            ST_PD_EXIT: begin
                if (win_zero) state_d = ST_ACTIVE;
            end
            default: state_d = ST_ACTIVE;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/lpseq_outdec.sv
`timescale 1ns/1ps
module lpseq_outdec
    import lpseq_pkg::*;
(
    input  lp_state_e  state,
    input  logic       dll_zero,
    output logic       cke,
    output logic [1:0] cmd_ovr,
    output logic       cmd_ok,
    output logic       rd_ok
);

    always_comb begin
        cke     = 1'b1;
        cmd_ovr = OVR_NOP;
        cmd_ok  = 1'b0;
        rd_ok   = 1'b0;
        unique case (state)
            ST_ACTIVE: begin
                cmd_ovr = OVR_NONE;
                cmd_ok  = 1'b1;
                rd_ok   = dll_zero;
            end
            ST_SR_ENTER: begin
                cke     = 1'b0;
                cmd_ovr = OVR_AREF;
            end
            ST_SR_HOLD, ST_PD_ENTER, ST_PD_HOLD: begin
                cke     = 1'b0;
            end
            ST_SR_EXIT, ST_PD_EXIT: begin
                cke     = 1'b1;
            end
            default: begin
                cke     = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/dram_lowpower_seq.sv
`timescale 1ns/1ps
module dram_lowpower_seq
    import lpseq_pkg::*;
#(
    parameter int XS_NOP_CYC  = 10,
    parameter int DLL_CYC     = 200,
    parameter int PD_EXIT_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sr_req,
    input  logic       pd_req,
    input  logic       banks_idle,
    input  logic       clk_stable,
    input  logic       refresh_due,
    output logic       cke,
    output logic [1:0] cmd_ovr,
    output logic       cmd_ok,
    output logic       rd_ok
);

    localparam int MAXC = (DLL_CYC > XS_NOP_CYC) ?
                          ((DLL_CYC > PD_EXIT_CYC) ? DLL_CYC : PD_EXIT_CYC) :
                          ((XS_NOP_CYC > PD_EXIT_CYC) ? XS_NOP_CYC : PD_EXIT_CYC);
    localparam int TW = $clog2(MAXC + 1);
    localparam logic [TW-1:0] XS_LOAD  = TW'(XS_NOP_CYC - 1);
    localparam logic [TW-1:0] PDX_LOAD = TW'(PD_EXIT_CYC - 1);
    localparam logic [TW-1:0] DLL_LOAD = TW'(DLL_CYC);

    initial begin
        if (XS_NOP_CYC < 1 || PD_EXIT_CYC < 1 || DLL_CYC < XS_NOP_CYC)
            $error("dram_lowpower_seq: illegal window parameters");
    end

    lp_state_e   st;
    logic        go_sr_exit, go_pd_exit;
    logic        win_zero, dll_zero;
    logic [TW-1:0] win_load_val;

    lpseq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sr_req      (sr_req),
        .pd_req      (pd_req),
        .banks_idle  (banks_idle),
        .clk_stable  (clk_stable),
        .refresh_due (refresh_due),
        .win_zero    (win_zero),
        .state       (st),
        .go_sr_exit  (go_sr_exit),
        .go_pd_exit  (go_pd_exit)
    );

    assign win_load_val = go_sr_exit ? XS_LOAD : PDX_LOAD;

    // NOP-only window after any clock-enable rise
    lpseq_timer #(.W(TW)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (go_sr_exit | go_pd_exit),
        .load_val (win_load_val),
        .zero     (win_zero)
    );

    // read-blocking window after self-refresh exit
    lpseq_timer #(.W(TW)) u_dll (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (go_sr_exit),
        .load_val (DLL_LOAD),
        .zero     (dll_zero)
    );

    lpseq_outdec u_dec (
        .state    (st),
        .dll_zero (dll_zero),
        .cke      (cke),
        .cmd_ovr  (cmd_ovr),
        .cmd_ok   (cmd_ok),
        .rd_ok    (rd_ok)
    );

endmodule

// File: rtl/dram_lowpower_seq_chk.sv
`timescale 1ns/1ps
module dram_lowpower_seq_chk #(
    parameter int DLL_CYC = 200
) (
    input logic       clk,
    input logic       rst_n,
    input logic       banks_idle,
    input logic       clk_stable,
    input logic       refresh_due,
    input logic       cke,
    input logic [1:0] cmd_ovr,
    input logic       cmd_ok,
    input logic       rd_ok
);

    logic cke_prev, in_sr;
    int   win_cnt;
    logic rise_sr;

    assign rise_sr = cke && !cke_prev && in_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cke_prev <= 1'b1;
            in_sr    <= 1'b0;
            win_cnt  <= 0;
        end else begin
            cke_prev <= cke;
            if (cmd_ovr == 2'b10) in_sr <= 1'b1;
            else if (rise_sr)     in_sr <= 1'b0;
            if (rise_sr)                              win_cnt <= 2;
            else if (win_cnt != 0 && win_cnt <= DLL_CYC) win_cnt <= win_cnt + 1;
        end
    end

    a_r9_ok_needs_cke: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ok |-> (cke && cmd_ovr == 2'b00));

    a_r9_low_cke_overridden: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> (cmd_ovr != 2'b00));

    a_r5_rd_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ok |-> cmd_ok);

    a_r2_entry_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cke) && cmd_ovr == 2'b10) |-> $past(banks_idle));

    a_r2_entry_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ovr == 2'b10) |=> (cmd_ovr == 2'b01 && !cke));

    a_r7_no_pd_when_due: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cke) && cmd_ovr == 2'b01) |-> !$past(refresh_due));

    a_r10_rise_needs_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> $past(clk_stable));

    a_r5_dll_window: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_sr || (win_cnt != 0 && win_cnt <= DLL_CYC)) |-> !rd_ok);

endmodule

bind dram_lowpower_seq dram_lowpower_seq_chk #(.DLL_CYC(DLL_CYC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .banks_idle  (banks_idle),
    .clk_stable  (clk_stable),
    .refresh_due (refresh_due),
    .cke         (cke),
    .cmd_ovr     (cmd_ovr),
    .cmd_ok      (cmd_ok),
    .rd_ok       (rd_ok)
);

// File: tb/dram_lowpower_seq_tb.sv
`timescale 1ns/1ps
module dram_lowpower_seq_tb;

    localparam int XS  = 10;
    localparam int DLL = 200;
    localparam int PDX = 2;

    localparam int M_A = 0, M_SE = 1, M_SR = 2, M_SX = 3, M_PE = 4, M_PD = 5, M_PX = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sr_req = 1'b0, pd_req = 1'b0, banks_idle = 1'b1;
    logic clk_stable = 1'b1, refresh_due = 1'b0;
    logic cke, cmd_ok, rd_ok;
    logic [1:0] cmd_ovr;

    int n_tests = 0, n_fail = 0;
    bit model_on = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dram_lowpower_seq #(.XS_NOP_CYC(XS), .DLL_CYC(DLL), .PD_EXIT_CYC(PDX)) u_dut (
        .clk(clk), .rst_n(rst_n), .sr_req(sr_req), .pd_req(pd_req),
        .banks_idle(banks_idle), .clk_stable(clk_stable), .refresh_due(refresh_due),
        .cke(cke), .cmd_ovr(cmd_ovr), .cmd_ok(cmd_ok), .rd_ok(rd_ok)
    );

    // reference model of the requirements
    int m_st, m_e, m_d;

    function automatic bit exp_cke(int s);
        return !(s == M_SE || s == M_SR || s == M_PE || s == M_PD);
    endfunction

    function automatic logic [1:0] exp_cmd(int s);
        if (s == M_A)  return 2'b00;
        if (s == M_SE) return 2'b10;
        return 2'b01;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = M_A; m_e = 0; m_d = DLL + 1;
        end else begin
            if (m_d <= DLL) m_d++;
            case (m_st)
                M_A:  if (sr_req) begin if (banks_idle) m_st = M_SE; end
                      else if (pd_req && !refresh_due) m_st = M_PE;
                M_SE: m_st = M_SR;
                M_SR: if (!sr_req && clk_stable) begin m_st = M_SX; m_e = 1; m_d = 1; end
                M_SX: if (m_e >= XS) m_st = M_A; else m_e++;
                M_PE: m_st = M_PD;
                M_PD: if ((!pd_req || refresh_due) && clk_stable) begin m_st = M_PX; m_e = 1; end
                M_PX: if (m_e >= PDX) m_st = M_A; else m_e++;
                default: m_st = M_A;
            endcase
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (model_on && rst_n && !done) begin
            chk("R2", "model cke", int'(cke), int'(exp_cke(m_st)));
            chk("R6", "model cmd_ovr", int'(cmd_ovr), int'(exp_cmd(m_st)));
            chk("R9", "model cmd_ok", int'(cmd_ok), int'(m_st == M_A));
            chk("R5", "model rd_ok", int'(rd_ok), int'(m_st == M_A && m_d > DLL));
        end
    end

    task automatic wait_n(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int lo_cmd, lo_rd;
        process::self().srandom(32'd1234);
        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "cke", int'(cke), 1);
        chk("R1", "cmd_ovr", int'(cmd_ovr), 0);
        chk("R1", "cmd_ok", int'(cmd_ok), 1);
        chk("R1", "rd_ok", int'(rd_ok), 1);
        model_on = 1'b1;

        // R3 pending self-refresh with busy banks, priority over power-down
        banks_idle = 1'b0; sr_req = 1'b1; pd_req = 1'b1;
        wait_n(5);
        chk("R3", "cke while pending", int'(cke), 1);
        chk("R3", "cmd_ok while pending", int'(cmd_ok), 1);
        banks_idle = 1'b1;
        @(negedge clk);
        chk("R2", "entry cke", int'(cke), 0);
        chk("R2", "entry cmd_ovr", int'(cmd_ovr), 2);
        @(negedge clk);
        chk("R2", "hold cmd_ovr", int'(cmd_ovr), 1);
        pd_req = 1'b0;

        // R10 exit blocked by unstable clock
        clk_stable = 1'b0; sr_req = 1'b0;
        wait_n(4);
        chk("R10", "cke held low", int'(cke), 0);
        clk_stable = 1'b1;
        @(negedge clk);
        chk("R4", "cke after exit", int'(cke), 1);
        lo_cmd = 0; lo_rd = 0;
        for (int i = 0; i < DLL + 20; i++) begin
            if (!cmd_ok) lo_cmd++;
            if (!rd_ok)  lo_rd++;
            @(negedge clk);
        end
        chk("R4", "NOP window length", lo_cmd, XS);
        chk("R5", "read block length", lo_rd, DLL);

        // R7 refresh due blocks power-down
        refresh_due = 1'b1; pd_req = 1'b1;
        wait_n(3);
        chk("R7", "cke with refresh due", int'(cke), 1);
        refresh_due = 1'b0;
        @(negedge clk);
        chk("R6", "pd entry cke", int'(cke), 0);
        chk("R6", "pd entry cmd", int'(cmd_ovr), 1);
        wait_n(2);
        // R8 forced exit on refresh due
        refresh_due = 1'b1;
        @(negedge clk);
        chk("R8", "cke after forced exit", int'(cke), 1);
        lo_cmd = 0;
        for (int i = 0; i < 10; i++) begin
            if (!cmd_ok) lo_cmd++;
            @(negedge clk);
        end
        chk("R8", "pd exit window", lo_cmd, PDX);
        chk("R8", "rd_ok after pd exit", int'(rd_ok), 1);
        refresh_due = 1'b0; pd_req = 1'b0;

        // random phase, checked by the model
        for (int i = 0; i < 8000; i++) begin
            if ($urandom_range(63) == 0) sr_req = ~sr_req;
            if ($urandom_range(39) == 0) pd_req = ~pd_req;
            if ($urandom_range(7) == 0)  banks_idle = ~banks_idle;
            if ($urandom_range(29) == 0) refresh_due = ~refresh_due;
            clk_stable = ($urandom_range(9) != 0);
            @(negedge clk);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule